// File: doc/BRIEF.md
# Sequenced Multi-Domain Reset Release Controller

This block turns one active-low asynchronous system reset into one active-low reset per clock domain. When the system reset goes low, every domain reset goes low at once, with no clock edge needed. When the system reset goes high again, each domain lets its own reset go on the rising edges of its own clock, through a short chain of flops. The output therefore never changes near an edge of that domain's clock.

A static policy input picks how the domains release. In independent mode, every domain starts its release as soon as the system reset goes high, so the domains finish in an order set only by their clock rates. In chained mode, the domains release one after another. The order input picks the direction: index 0 first (forward) or the highest index first (reverse). Each later domain waits until it has synchronised the released reset of the domain before it.

The policy and order inputs are captured on each domain's clock while that domain is still held in reset. They must be held stable until every domain has released.

Top module: `rstSeqCtrl`

## Requirements
- R1: When `sysRstN` falls, every bit of `domRstN` is 0 in the same instant, before any clock edge.
- R2: While `sysRstN` is 0, every bit of `domRstN` stays 0, whatever the clocks, `chainMode` or `revOrder` do.
- R3: Independent mode (`chainMode`=0). Domain i counts the rising edges of its own clock at which `sysRstN` is 1. Its output goes to 1 on the second such edge.
- R4: Forward chain (`chainMode`=1, `revOrder`=0). Domain 0 releases as in R3. Each domain i>0 goes to 1 on the second of its own rising edges at which `domRstN[i-1]` is 1. No domain is ever 1 while its predecessor is 0.
- R5: Reverse chain (`chainMode`=1, `revOrder`=1). Domain NUM_DOM-1 releases as in R3. Each domain i<NUM_DOM-1 goes to 1 on the second of its own rising edges at which `domRstN[i+1]` is 1. No domain is ever 1 while domain i+1 is 0.
- R6: Once a domain's output is 1, it stays 1 until `sysRstN` falls. Changing `chainMode` or `revOrder` while released has no effect on the outputs.
- R7: If `sysRstN` falls during a chained release, every domain returns to 0 at once. After the next rise, the sequence restarts from the first stage of the selected order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sysRstN | input | 1 | System reset, active low, asynchronous |
| domClk | input | NUM_DOM | One clock per domain, indexed by domain |
| chainMode | input | 1 | 0: independent release, 1: chained release |
| revOrder | input | 1 | Chain direction. 0: domain 0 first, 1: domain NUM_DOM-1 first |
| domRstN | output | NUM_DOM | Per-domain reset, active low |

## Verification
Three clocks with unrelated periods and non-aligned phases drive the block. The release is run in all three policies. Independent release shows that no domain waits for any other. The forward and reverse chains must show opposite staging, so a reversed or miswired predecessor link is caught. A reset pulse that cuts a forward chain off part way, and a policy change made after full release, separate a true restart and a frozen policy capture from designs that resume part way or keep sampling the policy inputs.

// File: rtl/rstSeqPkg.sv
`timescale 1ns/1ps
package rstSeqPkg;
  // One-hot choice of what the first flop of a domain loads on release
  typedef struct packed {
    logic takeOne;   // constant 1 (independent mode, or head of the chain)
    logic takePrev;  // released reset of domain index-1
    logic takeNext;  // released reset of domain index+1
  } feedStrb_t;
endpackage

// File: rtl/rstSeqPolicy.sv
`timescale 1ns/1ps
// Control: captures the release policy while this domain is held in reset
// and turns it into feed strobes for the synchroniser.
module rstSeqPolicy
  import rstSeqPkg::*;
#(
  parameter int NUM_DOM = 3,
  parameter int IDX     = 0
) (
  input  logic      clk,
  input  logic      ownRstN,
  input  logic      chainMode,
  input  logic      revOrder,
  output feedStrb_t strb
);
  localparam bit HEAD_FWD = (IDX == 0);
  localparam bit HEAD_REV = (IDX == NUM_DOM - 1);

  logic chainQ;
  logic revQ;

  // Policy only follows the inputs while this domain is still in reset.
  always_ff @(posedge clk) begin
    if (!ownRstN) begin
      chainQ <= chainMode;
      revQ   <= revOrder;
    end
  end

  always_comb begin
    strb = '0;
    if (!chainQ || (!revQ && HEAD_FWD) || (revQ && HEAD_REV)) begin
      strb.takeOne = 1'b1;
    end else if (!revQ) begin
      strb.takePrev = 1'b1;
    end else begin
      strb.takeNext = 1'b1;
    end
  end
endmodule

// File: rtl/rstSeqSync.sv
`timescale 1ns/1ps
// Datapath: asynchronously cleared flop chain, released on its own clock.
module rstSeqSync
  import rstSeqPkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic      clk,
  input  logic      sysRstN,
  input  feedStrb_t strb,
  input  logic      prevRstN,
  input  logic      nextRstN,
  output logic      rstN
);
  localparam int TOP = SYNC_DEPTH - 1;

  logic [TOP:0] shq;
  logic         feed;

  assign feed = strb.takeOne
              | (strb.takePrev & prevRstN)
              | (strb.takeNext & nextRstN);

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      shq <= '0;
    end else begin
      shq <= {shq[TOP-1:0], feed};
    end
  end

  assign rstN = shq[TOP];
endmodule

// File: rtl/rstSeqCtrl.sv
`timescale 1ns/1ps
module rstSeqCtrl
  import rstSeqPkg::*;
#(
  parameter int NUM_DOM    = 3,
  parameter int SYNC_DEPTH = 2
) (
  input  logic               sysRstN,
  input  logic [NUM_DOM-1:0] domClk,
  input  logic               chainMode,
  input  logic               revOrder,
  output logic [NUM_DOM-1:0] domRstN
);
  for (genvar d = 0; d < NUM_DOM; d++) begin : gDom
    feedStrb_t strb;
    logic      prevN;
    logic      nextN;

    if (d == 0) begin : gNoPrev
      assign prevN = 1'b1;
    end else begin : gPrev
      assign prevN = domRstN[d-1];
    end

    if (d == NUM_DOM - 1) begin : gNoNext
      assign nextN = 1'b1;
    end else begin : gNext
      assign nextN = domRstN[d+1];
    end

    rstSeqPolicy #(.NUM_DOM(NUM_DOM), .IDX(d)) uPol (
      .clk      (domClk[d]),
      .ownRstN  (domRstN[d]),
      .chainMode(chainMode),
      .revOrder (revOrder),
      .strb     (strb)
    );

    rstSeqSync #(.SYNC_DEPTH(SYNC_DEPTH)) uSync (
      .clk     (domClk[d]),
      .sysRstN (sysRstN),
      .strb    (strb),
      .prevRstN(prevN),
      .nextRstN(nextN),
      .rstN    (domRstN[d])
    );
  end
endmodule

// File: rtl/rstSeqChk.sv
`timescale 1ns/1ps
module rstSeqChk #(
  parameter int NUM_DOM = 3
) (
  input logic               sysRstN,
  input logic [NUM_DOM-1:0] domClk,
  input logic               chainMode,
  input logic               revOrder,
  input logic [NUM_DOM-1:0] domRstN
);
  for (genvar g = 0; g < NUM_DOM; g++) begin : gChk
    // R1 R2
    always @(posedge domClk[g]) begin
      if (!sysRstN) begin
        rst_low_chk: assert (!domRstN[g]) else $error("domain %0d not in reset", g);
      end
    end

    // R3
    rel_two_edge_chk: assert property (@(posedge domClk[g]) disable iff (!sysRstN)
      $rose(domRstN[g]) |-> ($past(sysRstN) && $past(sysRstN, 2)));

    // R6
    hold_high_chk: assert property (@(posedge domClk[g]) disable iff (!sysRstN)
      $past(domRstN[g]) |-> domRstN[g]);

    if (g > 0) begin : gFwd
      // R4
      fwd_order_chk: assert property (@(posedge domClk[g]) disable iff (!sysRstN)
        (chainMode && !revOrder && domRstN[g]) |-> domRstN[g-1]);
    end

    if (g < NUM_DOM - 1) begin : gRev
      // R5
      rev_order_chk: assert property (@(posedge domClk[g]) disable iff (!sysRstN)
        (chainMode && revOrder && domRstN[g]) |-> domRstN[g+1]);
    end
  end
endmodule

bind rstSeqCtrl rstSeqChk #(.NUM_DOM(NUM_DOM)) uChk (
  .sysRstN  (sysRstN),
  .domClk   (domClk),
  .chainMode(chainMode),
  .revOrder (revOrder),
  .domRstN  (domRstN)
);

// File: tb/sim_rstSeqCtrl.sv
`timescale 1ns/1ps
module sim_rstSeqCtrl;
  localparam int N = 3;

  logic         sysRstN = 1'b0;
  logic         c0 = 1'b0, c1 = 1'b0, c2 = 1'b0;
  logic [N-1:0] clkV;
  logic         chainMode = 1'b0, revOrder = 1'b0;
  logic [N-1:0] domRstN;
  logic [N-1:0] expV;

  int    nChk = 0, nBad = 0;
  bit    cmpOn = 1'b0, done = 1'b0;
  bit    mChain = 1'b0, mRev = 1'b0;
  string tag = "R2";

  assign clkV = {c2, c1, c0};

  rstSeqCtrl #(.NUM_DOM(N)) u0 (
    .sysRstN  (sysRstN),
    .domClk   (clkV),
    .chainMode(chainMode),
    .revOrder (revOrder),
    .domRstN  (domRstN)
  );

  // 50 MHz for domain 0; the others are unrelated and never share an edge time
  initial forever #10 c0 = ~c0;
  initial begin #5.3; forever begin c1 = ~c1; #13; end end
  initial begin #7.7; forever begin c2 = ~c2; #17; end end

  // Which domain a stage waits for under a policy; -1 means constant release
  function automatic int srcIdx(int i, bit ch, bit rv);
    if (!ch) return -1;
    if (!rv) return i - 1;
    return (i == N - 1) ? -1 : i + 1;
  endfunction

  // Behavioural model: count own edges with the release source high
  for (genvar i = 0; i < N; i++) begin : gM
    int   cnt = 0;
    logic eo = 1'b0;
    always @(posedge clkV[i] or negedge sysRstN) begin
      int   s;
      logic v;
      if (!sysRstN) begin
        cnt = 0;
        eo  = 1'b0;
      end else begin
        s   = srcIdx(i, mChain, mRev);
        v   = (s < 0) ? 1'b1 : expV[s];
        cnt = v ? cnt + 1 : 0;
        eo  = (cnt >= 2);
      end
    end
    assign expV[i] = eo;

    // Compare on every clock of this domain, away from its rising edge
    always @(negedge clkV[i]) begin
      int s;
      if (cmpOn) begin
        nChk++;
        if (domRstN[i] !== expV[i]) begin
          nBad++;
          $display("FAIL %s domain %0d: got %b expected %b", tag, i, domRstN[i], expV[i]);
        end
        s = srcIdx(i, mChain, mRev);
        if (mChain && s >= 0) begin
          nChk++;
          if (domRstN[i] === 1'b1 && domRstN[s] !== 1'b1) begin
            nBad++;
            $display("FAIL %s order domain %0d: got pred %b expected 1", tag, i, domRstN[s]);
          end
        end
      end
    end
  end

  task automatic chkVec(string t, logic [N-1:0] got, logic [N-1:0] exp);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: got %b expected %b", t, got, exp);
    end
  endtask

  task automatic chkBit(string t, logic got, logic exp);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: got %b expected %b", t, got, exp);
    end
  endtask

  // R1: outputs must already be low 0.1 ns after the fall, no edge in between
  task automatic assertRst();
    sysRstN = 1'b0;
    #0.1;
    chkVec("R1 async assert", domRstN, '0);
    #0.9;
  endtask

  task automatic setPolicy(bit ch, bit rv);
    chainMode = ch; revOrder = rv; mChain = ch; mRev = rv;
  endtask

  initial begin
    #100.5;
    chkVec("R2 reset state", domRstN, '0);
    chainMode = 1'b1; revOrder = 1'b1;
    #60;
    chkVec("R2 policy change during reset", domRstN, '0);
    setPolicy(1'b0, 1'b0);
    #100;
    cmpOn = 1'b1;

    // R3 independent release
    tag = "R3 independent";
    sysRstN = 1'b1;
    #800;
    chkVec("R3 all released", domRstN, '1);

    // R6 policy inputs ignored once released
    tag = "R6 frozen policy";
    chainMode = 1'b1; revOrder = 1'b1;
    #300;
    chkVec("R6 policy change after release", domRstN, '1);

    // R4 forward chain
    assertRst();
    tag = "R2 held";
    setPolicy(1'b1, 1'b0);
    #200;
    chkVec("R2 held before forward", domRstN, '0);
    tag = "R4 forward";
    sysRstN = 1'b1;
    #800;
    chkVec("R4 all released", domRstN, '1);

    // R5 reverse chain
    assertRst();
    tag = "R2 held";
    setPolicy(1'b1, 1'b1);
    #200;
    tag = "R5 reverse";
    sysRstN = 1'b1;
    #800;
    chkVec("R5 all released", domRstN, '1);

    // R7 reset cut into a forward chain part way, then restart
    assertRst();
    setPolicy(1'b1, 1'b0);
    #200;
    tag = "R7 restart";
    sysRstN = 1'b1;
    #60;
    chkBit("R7 last stage still held mid-chain", domRstN[N-1], 1'b0);
    assertRst();
    #200;
    sysRstN = 1'b1;
    #800;
    chkVec("R7 restarted chain completes", domRstN, '1);

    cmpOn = 1'b0;
    done  = 1'b1;
    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end
endmodule